// File: doc/BRIEF.md
# Magnetometer Result Bank Guard

This block sits between a magnetometer's measurement sequencer and its serial register interface. It owns the six result bytes for three axes. It decides when a freshly computed result may overwrite them, and it keeps three status flags: ready, lock and overwritten. It also drives an active-low data-ready pin and keeps the auto-incrementing register pointer that the bus side uses for burst reads.

A host reads the bank one byte per read strobe, always at the address held in the pointer. Once the host has taken one byte of a result, the bank is frozen until the whole result has been taken. This means a burst never mixes bytes from two measurements. A result that arrives while the bank is frozen waits in a one-deep holding slot. A newer arrival replaces it. The held result enters the bank in the cycle after the freeze is released. Each entry into the bank drops the ready flag and the data-ready pin for a minimum time, set by a parameter as a count of clocks.

Reads from addresses other than the result bytes and the status byte are served outside this block, so this block returns zero for them.

Top module: `magbank_guard`

## Requirements
- R1: The read data shows the byte at the pointer address. Address 3 holds the X high byte, 4 the X low byte, 5 the Z high byte, 6 the Z low byte, 7 the Y high byte and 8 the Y low byte, all in two's complement. Address 9 holds the status byte, with ready at bit 0, lock at bit 1, overwritten at bit 2 and zeros elsewhere. Every other address reads as zero.
- R2: Lock sets on a read of a result byte that leaves some of the six bytes unread since the last update. It also sets on a read at address 2, the mode register. While lock is set, the bank does not change. A result that arrives while locked goes to the holding slot, and a later arrival replaces it.
- R3: Lock clears on a mode write strobe or a configuration-A write strobe. It also clears on a measurement-start strobe once all six bytes have been read. A held result enters the bank in the cycle after the release.
- R4: When a result enters the bank, the ready flag clears and the data-ready pin goes low. Both stay low for exactly HOLD_CYC cycles, starting with the cycle after the update. At the end of that time the pin returns high and the ready flag sets.
- R5: The overwritten flag sets when a result arrives while the bank holds data that has not been fully read, or while a held result is still waiting.
- R6: The overwritten flag clears on any read of a result byte, unless a new setting condition occurs in the same cycle.
- R7: Each read strobe moves the pointer up by one, wrapping from 255 to 0. After a read at address 8, the pointer goes to 3 instead. A pointer-load strobe sets the pointer to the given value and takes priority over a read.
- R8: After reset, the pointer is 3, the bank bytes and all flags are zero, and the data-ready pin is high.
- R9: A result that arrives in a cycle with a read of a result byte or of address 2 is not written to the bank in that cycle. It goes to the holding slot instead.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ptr_set | input | 1 | Load the pointer from ptr_val |
| ptr_val | input | 8 | Pointer load value |
| rd_stb | input | 1 | One-byte read at the current pointer |
| mode_wr | input | 1 | Mode register written |
| cfga_wr | input | 1 | Configuration A register written |
| meas_start | input | 1 | Sequencer begins a new measurement |
| res_vld | input | 1 | New result on res_x, res_y, res_z |
| res_x | input | DATA_W | X axis result |
| res_y | input | DATA_W | Y axis result |
| res_z | input | DATA_W | Z axis result |
| reg_ptr | output | 8 | Current register pointer |
| rd_data | output | 8 | Byte at the pointer address |
| drdy_n | output | 1 | Data-ready pin, active low |

## Verification
The bench first takes a result with no reads pending and times the data-ready pulse and the ready flag against the hold count. It then runs full six-byte bursts, which show the pointer wrap and the byte order and separate a freeze that releases on a measurement start from one that does not. Partial bursts with a result arriving mid-burst show whether data is held back and the overwritten flag set. Separate releases through the mode write and the configuration write, a mode-register read, and a read coinciding with a new result each exercise a distinct path into or out of the freeze. An unlocked overwrite with a partly read bank confirms that the overwritten flag sets without any freeze.

// File: rtl/magbank_pkg.sv
`timescale 1ns/1ps
package magbank_pkg;
  localparam int unsigned ADDR_W  = 8;
  localparam logic [7:0]  A_MODE  = 8'd2;
  localparam logic [7:0]  A_FIRST = 8'd3;
  localparam int unsigned ST_RDY  = 0;
  localparam int unsigned ST_LOCK = 1;
  localparam int unsigned ST_OVR  = 2;
  localparam int unsigned N_AXIS  = 3;
endpackage

// File: rtl/magbank_ptr.sv
`timescale 1ns/1ps
module magbank_ptr #(
  parameter logic [7:0] FIRST = 8'd3,
  parameter logic [7:0] LAST  = 8'd8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ptr_set,
  input  logic [7:0] ptr_val,
  input  logic       rd_stb,
  output logic [7:0] ptr_q
);
  logic [7:0] ptr_d;
  logic       ptr_en;

  assign ptr_en = ptr_set | rd_stb;

  always_comb begin
    ptr_d = ptr_q;
    if (ptr_set) begin
      ptr_d = ptr_val;
    end else if (rd_stb) begin
      ptr_d = (ptr_q == LAST) ? FIRST : ptr_q + 8'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= FIRST;
    end else if (ptr_en) begin
      ptr_q <= ptr_d;
    end
  end
endmodule

// File: rtl/magbank_store.sv
`timescale 1ns/1ps
module magbank_store #(
  parameter  int unsigned DATA_W = 16,
  localparam int unsigned NB     = 3 * DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              res_vld,
  input  logic [DATA_W-1:0] res_x,
  input  logic [DATA_W-1:0] res_y,
  input  logic [DATA_W-1:0] res_z,
  input  logic [NB-1:0]     rd_hit,
  input  logic              mode_rd,
  input  logic              lock_q,
  output logic [NB*8-1:0]   bank_bytes,
  output logic              commit,
  output logic              full_after,
  output logic              ovr_set
);
  localparam int unsigned CW = 3 * DATA_W;

  logic [CW-1:0] res_cat, pend_q, src;
  logic          pend_v_q, pend_v_d, pend_ld;
  logic          bank_v_q;
  logic [NB-1:0] mask_q, mask_d, mask_seen;
  logic          mask_en, blk;

  // byte order in the bank: X, then Z, then Y, high byte first
  assign res_cat   = {res_x, res_z, res_y};
  assign blk       = (|rd_hit) | mode_rd;
  assign commit    = (res_vld | pend_v_q) & ~lock_q & ~blk;
  assign src       = res_vld ? res_cat : pend_q;
  assign mask_seen = mask_q | rd_hit;
  assign full_after = &mask_seen;
  assign ovr_set   = res_vld & ((bank_v_q & ~(&mask_q)) | pend_v_q);

  always_comb begin
    mask_d   = commit ? '0 : mask_seen;
    mask_en  = commit | (|rd_hit);
    pend_ld  = res_vld & ~commit;
    pend_v_d = commit ? 1'b0 : (res_vld ? 1'b1 : pend_v_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q   <= '0;
      pend_v_q <= 1'b0;
      bank_v_q <= 1'b0;
    end else begin
      if (mask_en) mask_q <= mask_d;
      pend_v_q <= pend_v_d;
      if (commit) bank_v_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
    end else if (pend_ld) begin
      pend_q <= res_cat;
    end
  end

  for (genvar i = 0; i < NB; i++) begin : g_byte
    logic [7:0] byte_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        byte_q <= '0;
      end else if (commit) begin
        byte_q <= src[CW-1-8*i -: 8];
      end
    end
    assign bank_bytes[i*8 +: 8] = byte_q;
  end
endmodule

// File: rtl/magbank_flags.sv
`timescale 1ns/1ps
module magbank_flags #(
  parameter  int unsigned HOLD_CYC = 40000,
  localparam int unsigned CNT_W    = $clog2(HOLD_CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic commit,
  input  logic data_rd,
  input  logic mode_rd,
  input  logic mode_wr,
  input  logic cfga_wr,
  input  logic meas_start,
  input  logic full_after,
  input  logic ovr_set,
  output logic lock_q,
  output logic rdy_q,
  output logic ovr_q,
  output logic drdy_n
);
  localparam logic [CNT_W-1:0] HOLD_V = CNT_W'(HOLD_CYC);
  localparam logic [CNT_W-1:0] ONE_V  = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic lock_d, rdy_d, ovr_d;

  always_comb begin
    lock_d = lock_q;
    if (mode_wr | cfga_wr) begin
      lock_d = 1'b0;
    end else if (mode_rd | (data_rd & ~full_after)) begin
      lock_d = 1'b1;
    end else if (meas_start & full_after) begin
      lock_d = 1'b0;
    end
  end

  always_comb begin
    cnt_d = cnt_q;
    rdy_d = rdy_q;
    if (commit) begin
      cnt_d = HOLD_V;
      rdy_d = 1'b0;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - ONE_V;
      if (cnt_q == ONE_V) rdy_d = 1'b1;
    end
  end

  always_comb begin
    ovr_d = ovr_q;
    if (ovr_set)      ovr_d = 1'b1;
    else if (data_rd) ovr_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= 1'b0;
      rdy_q  <= 1'b0;
      ovr_q  <= 1'b0;
      cnt_q  <= '0;
    end else begin
      lock_q <= lock_d;
      rdy_q  <= rdy_d;
      ovr_q  <= ovr_d;
      cnt_q  <= cnt_d;
    end
  end

  assign drdy_n = (cnt_q == '0);
endmodule

// File: rtl/magbank_guard.sv
`timescale 1ns/1ps
module magbank_guard #(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned HOLD_CYC = 40000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ptr_set,
  input  logic [7:0]        ptr_val,
  input  logic              rd_stb,
  input  logic              mode_wr,
  input  logic              cfga_wr,
  input  logic              meas_start,
  input  logic              res_vld,
  input  logic [DATA_W-1:0] res_x,
  input  logic [DATA_W-1:0] res_y,
  input  logic [DATA_W-1:0] res_z,
  output logic [7:0]        reg_ptr,
  output logic [7:0]        rd_data,
  output logic              drdy_n
);
  import magbank_pkg::*;

  localparam int unsigned NB       = 3 * DATA_W / 8;
  localparam logic [7:0]  A_LAST_L = A_FIRST + 8'(NB - 1);
  localparam logic [7:0]  A_STAT_L = A_LAST_L + 8'd1;

  logic [NB-1:0]   sel, rd_hit;
  logic [NB*8-1:0] bank_bytes;
  logic mode_rd, data_rd, commit, full_after, ovr_set;
  logic lock_q, rdy_q, ovr_q;

  for (genvar i = 0; i < NB; i++) begin : g_dec
    assign sel[i]    = (reg_ptr == A_FIRST + 8'(i));
    assign rd_hit[i] = rd_stb & sel[i];
  end

  assign mode_rd = rd_stb & (reg_ptr == A_MODE);
  assign data_rd = |rd_hit;

  magbank_ptr #(.FIRST(A_FIRST), .LAST(A_LAST_L)) u_ptr (
    .clk(clk), .rst_n(rst_n), .ptr_set(ptr_set), .ptr_val(ptr_val),
    .rd_stb(rd_stb), .ptr_q(reg_ptr)
  );

  magbank_store #(.DATA_W(DATA_W)) u_store (
    .clk(clk), .rst_n(rst_n), .res_vld(res_vld), .res_x(res_x),
    .res_y(res_y), .res_z(res_z), .rd_hit(rd_hit), .mode_rd(mode_rd),
    .lock_q(lock_q), .bank_bytes(bank_bytes), .commit(commit),
    .full_after(full_after), .ovr_set(ovr_set)
  );

  magbank_flags #(.HOLD_CYC(HOLD_CYC)) u_flags (
    .clk(clk), .rst_n(rst_n), .commit(commit), .data_rd(data_rd),
    .mode_rd(mode_rd), .mode_wr(mode_wr), .cfga_wr(cfga_wr),
    .meas_start(meas_start), .full_after(full_after), .ovr_set(ovr_set),
    .lock_q(lock_q), .rdy_q(rdy_q), .ovr_q(ovr_q), .drdy_n(drdy_n)
  );

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NB; i++) begin
      if (sel[i]) rd_data = bank_bytes[i*8 +: 8];
    end
    if (reg_ptr == A_STAT_L) begin
      rd_data[ST_RDY]  = rdy_q;
      rd_data[ST_LOCK] = lock_q;
      rd_data[ST_OVR]  = ovr_q;
    end
  end
endmodule

// File: rtl/magbank_guard_chk.sv
`timescale 1ns/1ps
module magbank_guard_chk #(
  parameter int unsigned HOLD_CYC  = 40000,
  parameter int unsigned NB        = 6,
  parameter logic [7:0]  PTR_FIRST = 8'd3,
  parameter logic [7:0]  PTR_LAST  = 8'd8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            lock_q,
  input logic            commit,
  input logic            rdy_q,
  input logic            ovr_q,
  input logic            drdy_n,
  input logic            res_vld,
  input logic            rd_stb,
  input logic            ptr_set,
  input logic            mode_wr,
  input logic            cfga_wr,
  input logic [7:0]      reg_ptr,
  input logic [NB*8-1:0] bank_bytes
);
  int low_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       low_run <= 0;
    else if (!drdy_n) low_run <= low_run + 1;
    else              low_run <= 0;
  end

  p_lock_freeze_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> $stable(bank_bytes));

  p_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_wr || cfga_wr) |=> !lock_q);

  p_update_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (!rdy_q && !drdy_n));

  p_drdy_min_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drdy_n) |-> (low_run >= int'(HOLD_CYC)));

  p_second_wait_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (res_vld && lock_q && $past(res_vld && lock_q)) |=> ovr_q);

  p_ptr_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !ptr_set && reg_ptr == PTR_LAST) |=> (reg_ptr == PTR_FIRST));

  p_read_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && reg_ptr >= PTR_FIRST && reg_ptr <= PTR_LAST) |-> !commit);
endmodule

bind magbank_guard magbank_guard_chk #(
  .HOLD_CYC(HOLD_CYC), .NB(NB), .PTR_FIRST(A_FIRST), .PTR_LAST(A_LAST_L)
) u_chk (
  .clk(clk), .rst_n(rst_n), .lock_q(lock_q), .commit(commit),
  .rdy_q(rdy_q), .ovr_q(ovr_q), .drdy_n(drdy_n), .res_vld(res_vld),
  .rd_stb(rd_stb), .ptr_set(ptr_set), .mode_wr(mode_wr),
  .cfga_wr(cfga_wr), .reg_ptr(reg_ptr), .bank_bytes(bank_bytes)
);

// File: tb/magbank_guard_bench.sv
`timescale 1ns/1ps
module magbank_guard_bench;
  localparam int H = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ptr_set = 0, rd_stb = 0, mode_wr = 0, cfga_wr = 0, meas_start = 0, res_vld = 0;
  logic [7:0]  ptr_val = '0;
  logic [15:0] res_x = '0, res_y = '0, res_z = '0;
  logic [7:0]  reg_ptr, rd_data;
  logic        drdy_n;

  always #2.5 clk = ~clk;

  magbank_guard #(.DATA_W(16), .HOLD_CYC(H)) u_magbank_guard (
    .clk(clk), .rst_n(rst_n), .ptr_set(ptr_set), .ptr_val(ptr_val),
    .rd_stb(rd_stb), .mode_wr(mode_wr), .cfga_wr(cfga_wr),
    .meas_start(meas_start), .res_vld(res_vld), .res_x(res_x),
    .res_y(res_y), .res_z(res_z), .reg_ptr(reg_ptr), .rd_data(rd_data),
    .drdy_n(drdy_n)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  task automatic chk(input string tag, input int got, input int expv);
    checks++;
    if (got !== expv) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, got, expv);
    end
  endtask

  // behavioural reference model
  int m_bank[6];
  int m_pend[6];
  bit [5:0] m_mask;
  bit m_bv, m_pv, m_lock, m_rdy, m_ovr;
  int m_cnt, m_ptr;

  always @(posedge clk or negedge rst_n) begin
    bit drd, mrd, cmt, full, oset;
    bit [5:0] seen;
    int nb[6];
    if (!rst_n) begin
      foreach (m_bank[k]) begin m_bank[k] = 0; m_pend[k] = 0; end
      m_mask = 0; m_bv = 0; m_pv = 0; m_lock = 0; m_rdy = 0; m_ovr = 0;
      m_cnt = 0; m_ptr = 3;
    end else begin
      drd  = rd_stb && m_ptr >= 3 && m_ptr <= 8;
      mrd  = rd_stb && m_ptr == 2;
      seen = m_mask;
      if (drd) seen[m_ptr-3] = 1'b1;
      full = (seen == 6'h3f);
      oset = res_vld && ((m_bv && m_mask != 6'h3f) || m_pv);
      cmt  = (res_vld || m_pv) && !m_lock && !drd && !mrd;
      nb[0] = res_x[15:8]; nb[1] = res_x[7:0];
      nb[2] = res_z[15:8]; nb[3] = res_z[7:0];
      nb[4] = res_y[15:8]; nb[5] = res_y[7:0];
      if (mode_wr || cfga_wr)            m_lock = 0;
      else if (mrd || (drd && !full))    m_lock = 1;
      else if (meas_start && full)       m_lock = 0;
      if (cmt) begin
        if (res_vld) m_bank = nb; else m_bank = m_pend;
        m_mask = 0; m_bv = 1; m_pv = 0; m_cnt = H; m_rdy = 0;
      end else begin
        m_mask = seen;
        if (res_vld) begin m_pv = 1; m_pend = nb; end
        if (m_cnt > 0) begin
          m_cnt--;
          if (m_cnt == 0) m_rdy = 1;
        end
      end
      if (oset) m_ovr = 1;
      else if (drd) m_ovr = 0;
      if (ptr_set)     m_ptr = ptr_val;
      else if (rd_stb) m_ptr = (m_ptr == 8) ? 3 : ((m_ptr + 1) & 255);
    end
  end

  function automatic int exp_rd();
    if (m_ptr >= 3 && m_ptr <= 8) return m_bank[m_ptr-3];
    if (m_ptr == 9) return (int'(m_ovr) << 2) | (int'(m_lock) << 1) | int'(m_rdy);
    return 0;
  endfunction

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R4 drdy_n vs model", drdy_n, (m_cnt == 0) ? 1 : 0);
      chk("R7 pointer vs model", reg_ptr, m_ptr);
      chk("R1 read data vs model", rd_data, exp_rd());
    end
  end

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    #1;
    ptr_set = 0; rd_stb = 0; mode_wr = 0; cfga_wr = 0; meas_start = 0; res_vld = 0;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) tick();
  endtask

  task automatic setp(input int a);
    ptr_set = 1; ptr_val = 8'(a); tick();
  endtask

  task automatic rd();
    rd_stb = 1; tick();
  endtask

  task automatic post(input int x, input int y, input int z);
    res_vld = 1; res_x = 16'(x); res_y = 16'(y); res_z = 16'(z); tick();
  endtask

  task automatic summary();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
  end

  initial begin
    int expa[6];
    expa = '{8'h01, 8'h23, 8'h04, 8'h56, 8'hFE, 8'hDC};
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    #1;
    chk("R8 pointer after reset", reg_ptr, 3);
    chk("R8 bank after reset", rd_data, 0);
    chk("R8 drdy_n after reset", drdy_n, 1);
    setp(9);
    chk("R8 status after reset", rd_data, 0);

    post(16'h0123, 16'hFEDC, 16'h0456);
    chk("R4 pin low after update", drdy_n, 0);
    chk("R4 ready clear after update", rd_data, 0);
    idle(H - 1);
    chk("R4 pin still low at end of hold", drdy_n, 0);
    idle(1);
    chk("R4 pin high after hold", drdy_n, 1);
    chk("R4 ready set after hold", rd_data, 1);

    setp(3);
    for (int i = 0; i < 6; i++) begin
      chk("R1 byte order", rd_data, expa[i]);
      rd();
    end
    chk("R7 wrap after last data byte", reg_ptr, 3);
    setp(9);
    chk("R2 lock after burst", rd_data, 3);

    post(16'h0ABC, 16'h0011, 16'hF800);
    chk("R5 no overwrite when fully read", rd_data, 3);
    chk("R2 no update while locked", drdy_n, 1);
    meas_start = 1; tick();
    chk("R3 release on measurement start", rd_data, 1);
    tick();
    chk("R3 held result enters bank", drdy_n, 0);
    idle(H);

    setp(3);
    chk("R3 new X high byte", rd_data, 8'h0A);
    rd();
    chk("R1 X low byte", rd_data, 8'hBC);
    rd();
    setp(9);
    chk("R2 lock after partial read", rd_data, 3);
    post(16'h0001, 16'h0002, 16'h0003);
    chk("R5 overwritten on partial read", rd_data, 7);
    chk("R2 no update during partial burst", drdy_n, 1);
    setp(3);
    chk("R2 bank held", rd_data, 8'h0A);
    rd();
    setp(9);
    chk("R6 overwritten cleared by read", rd_data, 3);
    cfga_wr = 1; tick();
    chk("R3 release on config write", rd_data, 1);
    tick();
    chk("R3 held result after config write", drdy_n, 0);
    setp(3);
    chk("R3 held value X high", rd_data, 8'h00);
    rd();
    chk("R3 held value X low", rd_data, 8'h01);
    idle(H);

    mode_wr = 1; tick();
    rd_stb = 1; res_vld = 1; res_x = 16'h0100; res_y = 16'h0200; res_z = 16'h0300;
    tick();
    setp(9);
    chk("R9 result deferred by read", rd_data, 7);
    chk("R9 no update with read", drdy_n, 1);
    mode_wr = 1; tick();
    setp(3);
    chk("R3 release on mode write", drdy_n, 0);
    chk("R9 deferred result in bank", rd_data, 8'h01);
    idle(H);

    setp(2);
    rd();
    post(16'h07FF, 16'h0000, 16'h0000);
    setp(9);
    chk("R2 lock on mode read", rd_data, 7);
    mode_wr = 1; tick();
    setp(3);
    chk("R3 held result after mode write", rd_data, 8'h07);
    idle(H);

    rd();
    mode_wr = 1; tick();
    post(16'h0555, 16'h0000, 16'h0000);
    chk("R5 unlocked overwrite updates", drdy_n, 0);
    chk("R5 new low byte", rd_data, 8'h55);
    setp(9);
    chk("R5 overwritten flag", rd_data, 4);

    setp(255);
    rd();
    chk("R7 wrap at 255", reg_ptr, 0);
    chk("R1 other address reads zero", rd_data, 0);
    setp(10);
    chk("R7 pointer load", reg_ptr, 10);
    chk("R1 address 10 reads zero", rd_data, 0);
    idle(H + 2);
    summary();
  end
endmodule